// File: doc/BRIEF.md
# Tetrahedral 3D Color Lookup

This block replaces each incoming RGB pixel with a colour read out of a programmable three-axis lattice, blending the stored lattice points around the pixel by tetrahedral interpolation. It sits after a one-dimensional curve stage that has already normalised each component to the full 12-bit code range, so the whole input cube spans the lattice.

The lattice has either 17 or 9 points per axis. Software fills it through a streaming load port: a start strobe rewinds the write position and every write cycle stores one RGB entry. The stored components can be treated as 12-bit or 10-bit values. Until a complete table is present, or whenever the lookup is switched off, pixels leave unchanged. In every mode, each pixel takes the same number of cycles to cross the block.

Top module: `color_cube_lut`

## Requirements
- R1: `out_valid` follows `in_valid` exactly 4 clock cycles later, both in lookup and in pass-through operation.
- R2: When `lut_en` is low or `tbl_ready` is low at the input cycle, the output pixel 4 cycles later equals the input pixel bit for bit.
- R3: `tbl_ready` goes high on the clock edge that takes the last entry of a load, 4913 entries when `grid_sel` was 0 at the start strobe and 729 when it was 1, and stays low before that edge; a start strobe clears it and rewinds the write position (a write in the start cycle is entry zero).
- R4: `tbl_err` is set, and `tbl_ready` cleared, by a write arriving when no load is open (a write past the last entry, or before any start); a start strobe while a load is partly written sets `tbl_err`, and any other start strobe clears it.
- R5: Loaded entries fill the lattice with the red index changing fastest, then green, with blue slowest.
- R6: With the 17-point lattice, input bits [11:8] of a component select the cell and bits [7:0] the fraction; a pixel whose three components all have zero fraction returns the stored entry at those indices exactly.
- R7: Inside a cell the three fractions, as 9-bit values f out of 512, are ordered largest first (a >= b >= c); the result is (512-a)*P0 + (a-b)*P1 + (b-c)*P2 + c*P3, where P0 is the cell base corner, P1 steps along the axis of a, P2 steps further along the axis of b and P3 is the opposite corner.
- R8: The weighted sum is divided by 512 with rounding half up and limited to the largest code of the active precision.
- R9: With `prec_sel` high only the low 10 bits of each stored component are used, the result is rounded at 10 bits and then shifted left by 2, so the output low 2 bits are zero.
- R10: With the 9-point lattice, input bits [11:9] select the cell and bits [8:0] the fraction.
- R11: The full-scale code 4095 stays in the last cell with fraction 255/256 (17 points) or 511/512 (9 points) and never indexes beyond the lattice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lut_en | input | 1 | Lookup enable; low forces pass-through |
| grid_sel | input | 1 | Lattice size for the next load: 0 = 17 points, 1 = 9 points |
| prec_sel | input | 1 | Entry precision: 0 = 12 bit, 1 = 10 bit |
| ld_start | input | 1 | Start of a table load |
| ld_wr | input | 1 | Write one lattice entry |
| ld_r | input | 12 | Red component of the entry |
| ld_g | input | 12 | Green component of the entry |
| ld_b | input | 12 | Blue component of the entry |
| tbl_ready | output | 1 | A complete table is stored |
| tbl_err | output | 1 | Load sequence error |
| in_valid | input | 1 | Input pixel qualifier |
| in_r | input | 12 | Input red |
| in_g | input | 12 | Input green |
| in_b | input | 12 | Input blue |
| out_valid | output | 1 | Output pixel qualifier |
| out_r | output | 12 | Output red |
| out_g | output | 12 | Output green |
| out_b | output | 12 | Output blue |

## Verification
Each pixel result is due on the fourth rising edge after the edge that takes the input, so the bench drives a single pixel on a falling edge, confirms that nothing is valid after three edges and compares the output after the fourth. The load flags change on the very edge that takes the write or start, so they are read on the falling edge straight after it, with `tbl_ready` checked both while the final entry is presented and once it has been taken. Expected colours come from a bench-side table function and an independent sort-based evaluation of the interpolation rule.

// File: rtl/cclut_pkg.sv
`timescale 1ns/1ps
package cclut_pkg;
   localparam int unsigned CLUT_CW = 12;

   // which axis grows first, second, third inside a cell
   typedef enum logic [2:0] {
      ORD_RGB, ORD_RBG, ORD_BRG, ORD_GRB, ORD_GBR, ORD_BGR
   } tet_order_e;

   // corner step masks, bit2 = blue, bit1 = green, bit0 = red
   localparam logic [2:0] STEP_R = 3'b001;
   localparam logic [2:0] STEP_G = 3'b010;
   localparam logic [2:0] STEP_B = 3'b100;
endpackage

// File: rtl/cclut_loader.sv
`timescale 1ns/1ps
module cclut_loader #(
   parameter int unsigned CW       = 12,
   parameter int unsigned GRID_MAX = 17,
   parameter int unsigned GRID_MIN = 9,
   parameter int unsigned HALF     = 9,
   parameter int unsigned IDXW     = 5,
   parameter int unsigned AW       = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              wr,
   input  logic              grid_sel,
   input  logic [CW-1:0]     dr,
   input  logic [CW-1:0]     dg,
   input  logic [CW-1:0]     db,
   output logic              wr_en,
   output logic [2:0]        wr_bank,
   output logic [AW-1:0]     wr_addr,
   output logic [3*CW-1:0]   wr_data,
   output logic              ready,
   output logic              err,
   output logic              grid_q
);
   localparam logic [IDXW-1:0] LIM_BIG   = IDXW'(GRID_MAX - 1);
   localparam logic [IDXW-1:0] LIM_SMALL = IDXW'(GRID_MIN - 1);

   logic [IDXW-1:0] ir, ig, ib;
   logic            open_q, touched;
   logic [IDXW-1:0] e_r, e_g, e_b, lim;
   logic [IDXW-1:0] n_r, n_g, n_b;
   logic            e_open, e_grid, last;

   always_comb begin
      e_r    = start ? '0 : ir;
      e_g    = start ? '0 : ig;
      e_b    = start ? '0 : ib;
      e_open = start | open_q;
      e_grid = start ? grid_sel : grid_q;
      lim    = e_grid ? LIM_SMALL : LIM_BIG;
      last   = (e_r == lim) && (e_g == lim) && (e_b == lim);
      n_r = e_r + 1'b1;
      n_g = e_g;
      n_b = e_b;
      if (e_r == lim) begin
         n_r = '0;
         n_g = e_g + 1'b1;
         if (e_g == lim) begin
            n_g = '0;
            n_b = e_b + 1'b1;
         end
      end
   end

   // red fastest, blue slowest; parity of each index picks the bank
   assign wr_en   = wr & e_open;
   assign wr_bank = {e_b[0], e_g[0], e_r[0]};
   assign wr_addr = AW'(32'(e_b >> 1) * HALF * HALF + 32'(e_g >> 1) * HALF + 32'(e_r >> 1));
   assign wr_data = {dr, dg, db};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ir <= '0; ig <= '0; ib <= '0;
         open_q  <= 1'b0;
         touched <= 1'b0;
         ready   <= 1'b0;
         err     <= 1'b0;
         grid_q  <= 1'b0;
      end else begin
         if (start) begin
            err    <= open_q & touched;
            ready  <= 1'b0;
            grid_q <= grid_sel;
         end
         if (wr && e_open) begin
            ir <= n_r; ig <= n_g; ib <= n_b;
            touched <= 1'b1;
            open_q  <= !last;
            ready   <= last;
         end else if (wr) begin
            err   <= 1'b1;
            ready <= 1'b0;
         end else if (start) begin
            ir <= '0; ig <= '0; ib <= '0;
            open_q  <= 1'b1;
            touched <= 1'b0;
         end
      end
   end

   p_ready_by_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(wr));
   p_stray_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !start && !open_q) |=> (err && !ready));
   p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && open_q && touched) |=> err);
endmodule

// File: rtl/cclut_banks.sv
`timescale 1ns/1ps
module cclut_banks #(
   parameter int unsigned CW    = 12,
   parameter int unsigned HALF  = 9,
   parameter int unsigned DEPTH = 729,
   parameter int unsigned IDXW  = 5,
   parameter int unsigned AW    = 10
) (
   input  logic                   clk,
   input  logic                   wr_en,
   input  logic [2:0]             wr_bank,
   input  logic [AW-1:0]          wr_addr,
   input  logic [3*CW-1:0]        wr_data,
   input  logic [IDXW-1:0]        base_r,
   input  logic [IDXW-1:0]        base_g,
   input  logic [IDXW-1:0]        base_b,
   output logic [7:0][3*CW-1:0]   rd_q
);
   // half index of whichever of {base, base+1} has parity p
   function automatic logic [IDXW-1:0] pick_half(input logic [IDXW-1:0] base, input logic p);
      logic [IDXW-1:0] up;
      up = base + 1'b1;
      return (base[0] == p) ? (base >> 1) : (up >> 1);
   endfunction

   for (genvar k = 0; k < 8; k++) begin : g_bank
      localparam logic PR = k[0];
      localparam logic PG = k[1];
      localparam logic PB = k[2];
      logic [3*CW-1:0] mem [DEPTH];
      logic [3*CW-1:0] q;
      logic [IDXW-1:0] hr, hg, hb;
      logic [AW-1:0]   ra;

      assign hr = pick_half(base_r, PR);
      assign hg = pick_half(base_g, PG);
      assign hb = pick_half(base_b, PB);
      assign ra = AW'(32'(hb) * HALF * HALF + 32'(hg) * HALF + 32'(hr));

      always_ff @(posedge clk) begin
         if (wr_en && (wr_bank == 3'(k))) mem[wr_addr] <= wr_data;
         q <= mem[ra];
      end
      assign rd_q[k] = q;
   end
endmodule

// File: rtl/cclut_tetra.sv
`timescale 1ns/1ps
module cclut_tetra
   import cclut_pkg::*;
#(
   parameter int unsigned CW   = 12,
   parameter int unsigned FW   = 9,
   parameter int unsigned DROP = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  v1,
   input  logic                  byp1,
   input  logic                  low1,
   input  logic [2:0]            par1,
   input  logic [FW-1:0]         fr1,
   input  logic [FW-1:0]         fg1,
   input  logic [FW-1:0]         fb1,
   input  logic [3*CW-1:0]       pix1,
   input  logic [7:0][3*CW-1:0]  bank_q,
   output logic                  out_valid,
   output logic [3*CW-1:0]       out_pix
);
   localparam int unsigned WW   = FW + 1;
   localparam int unsigned ACCW = CW + FW + 3;
   localparam logic [WW-1:0]   ONE    = WW'(1 << FW);
   localparam logic [ACCW-1:0] HALFU  = ACCW'(1 << (FW - 1));
   localparam logic [CW-1:0]   KEEP10 = CW'((1 << (CW - DROP)) - 1);
   localparam logic [CW+2:0]   MAX_HI = (CW+3)'((1 << CW) - 1);
   localparam logic [CW+2:0]   MAX_LO = (CW+3)'((1 << (CW - DROP)) - 1);

   // ---- stage 2: order fractions, pick corners and weights
   tet_order_e      ord;
   logic [2:0]      st1, st2;
   logic [FW-1:0]   fa, fb_, fc;
   logic [3:0][3*CW-1:0] cn;
   logic            rg, gb, rb;

   always_comb begin
      rg = fr1 >= fg1;
      gb = fg1 >= fb1;
      rb = fr1 >= fb1;
      if (rg && gb)       ord = ORD_RGB;
      else if (rg && rb)  ord = ORD_RBG;
      else if (rg)        ord = ORD_BRG;
      else if (gb && rb)  ord = ORD_GRB;
      else if (gb)        ord = ORD_GBR;
      else                ord = ORD_BGR;
      unique case (ord)
         ORD_RGB: begin st1 = STEP_R; st2 = STEP_R | STEP_G; fa = fr1; fb_ = fg1; fc = fb1; end
         ORD_RBG: begin st1 = STEP_R; st2 = STEP_R | STEP_B; fa = fr1; fb_ = fb1; fc = fg1; end
         ORD_BRG: begin st1 = STEP_B; st2 = STEP_B | STEP_R; fa = fb1; fb_ = fr1; fc = fg1; end
         ORD_GRB: begin st1 = STEP_G; st2 = STEP_G | STEP_R; fa = fg1; fb_ = fr1; fc = fb1; end
         ORD_GBR: begin st1 = STEP_G; st2 = STEP_G | STEP_B; fa = fg1; fb_ = fb1; fc = fr1; end
         default: begin st1 = STEP_B; st2 = STEP_B | STEP_G; fa = fb1; fb_ = fg1; fc = fr1; end
      endcase
      cn[0] = bank_q[par1];
      cn[1] = bank_q[par1 ^ st1];
      cn[2] = bank_q[par1 ^ st2];
      cn[3] = bank_q[par1 ^ 3'b111];
      if (low1) begin
         for (int i = 0; i < 4; i++)
            cn[i] = {cn[i][3*CW-1 -: CW] & KEEP10, cn[i][2*CW-1 -: CW] & KEEP10,
                     cn[i][CW-1:0] & KEEP10};
      end
   end

   logic                 v2, byp2, low2;
   logic [3*CW-1:0]      pix2;
   logic [3:0][3*CW-1:0] c2;
   logic [3:0][WW-1:0]   w2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v2 <= 1'b0; byp2 <= 1'b0; low2 <= 1'b0;
         pix2 <= '0; c2 <= '0; w2 <= '0;
      end else begin
         v2   <= v1;
         byp2 <= byp1;
         low2 <= low1;
         pix2 <= pix1;
         c2   <= cn;
         w2[0] <= ONE - WW'(fa);
         w2[1] <= WW'(fa) - WW'(fb_);
         w2[2] <= WW'(fb_) - WW'(fc);
         w2[3] <= WW'(fc);
      end
   end

   // ---- stage 3: weighted sum per channel
   logic [2:0][ACCW-1:0] acc_d;
   for (genvar ch = 0; ch < 3; ch++) begin : g_mac
      localparam int unsigned HI = (3 - ch) * CW - 1;
      assign acc_d[ch] = ACCW'(w2[0]) * ACCW'(c2[0][HI -: CW])
                       + ACCW'(w2[1]) * ACCW'(c2[1][HI -: CW])
                       + ACCW'(w2[2]) * ACCW'(c2[2][HI -: CW])
                       + ACCW'(w2[3]) * ACCW'(c2[3][HI -: CW]);
   end

   logic                 v3, byp3, low3;
   logic [3*CW-1:0]      pix3;
   logic [2:0][ACCW-1:0] acc3;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v3 <= 1'b0; byp3 <= 1'b0; low3 <= 1'b0; pix3 <= '0; acc3 <= '0;
      end else begin
         v3 <= v2; byp3 <= byp2; low3 <= low2; pix3 <= pix2; acc3 <= acc_d;
      end
   end

   // ---- stage 4: round, saturate, align
   logic [3*CW-1:0] res_d;
   for (genvar ch = 0; ch < 3; ch++) begin : g_fin
      localparam int unsigned HI = (3 - ch) * CW - 1;
      logic [ACCW-1:0] sh;
      logic [CW+2:0]   rnd, lim;
      logic [CW-1:0]   sat;
      assign sh  = (acc3[ch] + HALFU) >> FW;
      assign rnd = sh[CW+2:0];
      assign lim = low3 ? MAX_LO : MAX_HI;
      assign sat = (rnd > lim) ? lim[CW-1:0] : rnd[CW-1:0];
      assign res_d[HI -: CW] = low3 ? (sat << DROP) : sat;
   end

   logic low4, byp4;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0; out_pix <= '0; low4 <= 1'b0; byp4 <= 1'b0;
      end else begin
         out_valid <= v3;
         out_pix   <= byp3 ? pix3 : res_d;
         low4      <= low3;
         byp4      <= byp3;
      end
   end

   p_weight_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (v2 && !byp2) |-> ((FW+3)'(w2[0]) + (FW+3)'(w2[1]) + (FW+3)'(w2[2]) + (FW+3)'(w2[3])
                         == (FW+3)'(ONE)));
   p_low_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && low4 && !byp4) |->
         (out_pix[2*CW+DROP-1:2*CW] == '0 && out_pix[CW+DROP-1:CW] == '0 &&
          out_pix[DROP-1:0] == '0));
endmodule

// File: rtl/color_cube_lut.sv
`timescale 1ns/1ps
module color_cube_lut
   import cclut_pkg::*;
#(
   parameter int unsigned CW       = CLUT_CW,
   parameter int unsigned GRID_MAX = 17,
   parameter int unsigned DROP     = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lut_en,
   input  logic          grid_sel,
   input  logic          prec_sel,
   input  logic          ld_start,
   input  logic          ld_wr,
   input  logic [CW-1:0] ld_r,
   input  logic [CW-1:0] ld_g,
   input  logic [CW-1:0] ld_b,
   output logic          tbl_ready,
   output logic          tbl_err,
   input  logic          in_valid,
   input  logic [CW-1:0] in_r,
   input  logic [CW-1:0] in_g,
   input  logic [CW-1:0] in_b,
   output logic          out_valid,
   output logic [CW-1:0] out_r,
   output logic [CW-1:0] out_g,
   output logic [CW-1:0] out_b
);
   localparam int unsigned CELLB    = $clog2(GRID_MAX - 1);
   localparam int unsigned IDXW     = CELLB + 1;
   localparam int unsigned FW       = CW - CELLB + 1;
   localparam int unsigned GRID_MIN = (GRID_MAX - 1) / 2 + 1;
   localparam int unsigned HALF     = (GRID_MAX + 1) / 2;
   localparam int unsigned DEPTH    = HALF * HALF * HALF;
   localparam int unsigned AW       = $clog2(DEPTH);

   if (GRID_MAX < 5 || ((GRID_MAX - 1) & (GRID_MAX - 2)) != 0) begin : g_bad_grid
      $error("GRID_MAX must be a power of two plus one, at least 5");
   end
   if (CW < CELLB + 2) begin : g_bad_cw
      $error("component width too small for the lattice");
   end
   if (DROP == 0 || DROP >= CW) begin : g_bad_drop
      $error("DROP must lie between 1 and CW-1");
   end

   // ---- table load
   logic              wr_en, grid_q;
   logic [2:0]        wr_bank;
   logic [AW-1:0]     wr_addr;
   logic [3*CW-1:0]   wr_data;

   cclut_loader #(.CW(CW), .GRID_MAX(GRID_MAX), .GRID_MIN(GRID_MIN), .HALF(HALF),
                  .IDXW(IDXW), .AW(AW)) u_load (
      .clk(clk), .rst_n(rst_n), .start(ld_start), .wr(ld_wr), .grid_sel(grid_sel),
      .dr(ld_r), .dg(ld_g), .db(ld_b),
      .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
      .ready(tbl_ready), .err(tbl_err), .grid_q(grid_q));

   // ---- cell and fraction split
   function automatic logic [IDXW+FW-1:0] split(input logic [CW-1:0] px, input logic coarse);
      if (coarse) return {2'b00, px[CW-1 -: CELLB-1], px[FW-1:0]};
      else        return {1'b0, px[CW-1 -: CELLB], px[CW-CELLB-1:0], 1'b0};
   endfunction

   logic [IDXW+FW-1:0] s_r, s_g, s_b;
   assign s_r = split(in_r, grid_q);
   assign s_g = split(in_g, grid_q);
   assign s_b = split(in_b, grid_q);

   logic [7:0][3*CW-1:0] bank_q;
   cclut_banks #(.CW(CW), .HALF(HALF), .DEPTH(DEPTH), .IDXW(IDXW), .AW(AW)) u_banks (
      .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
      .base_r(s_r[IDXW+FW-1:FW]), .base_g(s_g[IDXW+FW-1:FW]), .base_b(s_b[IDXW+FW-1:FW]),
      .rd_q(bank_q));

   // ---- stage 1 (aligned with the bank read)
   logic            byp_in;
   logic            v1, byp1, low1;
   logic [2:0]      par1;
   logic [FW-1:0]   fr1, fg1, fb1;
   logic [3*CW-1:0] pix1;

   assign byp_in = !(lut_en && tbl_ready);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1 <= 1'b0; byp1 <= 1'b0; low1 <= 1'b0; par1 <= '0;
         fr1 <= '0; fg1 <= '0; fb1 <= '0; pix1 <= '0;
      end else begin
         v1   <= in_valid;
         byp1 <= byp_in;
         low1 <= prec_sel;
         par1 <= {s_b[FW], s_g[FW], s_r[FW]};
         fr1  <= s_r[FW-1:0];
         fg1  <= s_g[FW-1:0];
         fb1  <= s_b[FW-1:0];
         pix1 <= {in_r, in_g, in_b};
      end
   end

   logic [3*CW-1:0] out_pix;
   cclut_tetra #(.CW(CW), .FW(FW), .DROP(DROP)) u_tetra (
      .clk(clk), .rst_n(rst_n), .v1(v1), .byp1(byp1), .low1(low1), .par1(par1),
      .fr1(fr1), .fg1(fg1), .fb1(fb1), .pix1(pix1), .bank_q(bank_q),
      .out_valid(out_valid), .out_pix(out_pix));

   assign out_r = out_pix[3*CW-1 -: CW];
   assign out_g = out_pix[2*CW-1 -: CW];
   assign out_b = out_pix[CW-1:0];

   // ---- checks over the whole pipe
   logic [2:0] warm_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)               warm_cnt <= '0;
      else if (warm_cnt != 3'd7) warm_cnt <= warm_cnt + 1'b1;
   end

   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_cnt == 3'd7) |-> (out_valid == $past(in_valid, 4)));
   p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((warm_cnt == 3'd7) && $past(in_valid && byp_in, 4)) |->
         ({out_r, out_g, out_b} == $past({in_r, in_g, in_b}, 4)));
endmodule

// File: tb/color_cube_lut_test.sv
`timescale 1ns/1ps
module color_cube_lut_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lut_en = 1'b0, grid_sel = 1'b0, prec_sel = 1'b0;
   logic ld_start = 1'b0, ld_wr = 1'b0;
   logic [11:0] ld_r = '0, ld_g = '0, ld_b = '0;
   logic tbl_ready, tbl_err;
   logic in_valid = 1'b0;
   logic [11:0] in_r = '0, in_g = '0, in_b = '0;
   logic out_valid;
   logic [11:0] out_r, out_g, out_b;

   int total = 0, bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   color_cube_lut uut (
      .clk(clk), .rst_n(rst_n), .lut_en(lut_en), .grid_sel(grid_sel), .prec_sel(prec_sel),
      .ld_start(ld_start), .ld_wr(ld_wr), .ld_r(ld_r), .ld_g(ld_g), .ld_b(ld_b),
      .tbl_ready(tbl_ready), .tbl_err(tbl_err),
      .in_valid(in_valid), .in_r(in_r), .in_g(in_g), .in_b(in_b),
      .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b));

   task automatic check(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // table content as a function of lattice indices
   function automatic int ent(int ch, int r, int g, int b);
      if (ch == 0)      return r * 200 + g * 10 + b * 5;
      else if (ch == 1) return g * 150 + r * g * 5;
      else              return b * b * 10 + r;
   endfunction

   // interpolation rule written from the requirements (sort, then weights)
   function automatic int model(int ch, int pr, int pg, int pb, bit g9, bit low);
      int p[3], cl[3], f[3], ax[3], d[3], v[4], t, acc, res, lim;
      p[0] = pr; p[1] = pg; p[2] = pb;
      for (int i = 0; i < 3; i++) begin
         if (g9) begin cl[i] = p[i] / 512; f[i] = p[i] % 512; end
         else    begin cl[i] = p[i] / 256; f[i] = (p[i] % 256) * 2; end
         ax[i] = i; d[i] = 0;
      end
      if (f[ax[1]] > f[ax[0]]) begin t = ax[0]; ax[0] = ax[1]; ax[1] = t; end
      if (f[ax[2]] > f[ax[1]]) begin t = ax[1]; ax[1] = ax[2]; ax[2] = t; end
      if (f[ax[1]] > f[ax[0]]) begin t = ax[0]; ax[0] = ax[1]; ax[1] = t; end
      for (int k = 0; k < 4; k++) begin
         if (k > 0) d[ax[k-1]] = 1;
         v[k] = ent(ch, cl[0] + d[0], cl[1] + d[1], cl[2] + d[2]);
         if (low) v[k] = v[k] % 1024;
      end
      acc = (512 - f[ax[0]]) * v[0] + (f[ax[0]] - f[ax[1]]) * v[1]
          + (f[ax[1]] - f[ax[2]]) * v[2] + f[ax[2]] * v[3];
      res = (acc + 256) / 512;
      lim = low ? 1023 : 4095;
      if (res > lim) res = lim;
      if (low) res = res * 4;
      return res;
   endfunction

   // one pixel in, result due on the 4th edge after it is taken
   task automatic pixel(string tag, int r, int g, int b, int er, int eg, int eb);
      @(negedge clk);
      in_valid = 1'b1; in_r = 12'(r); in_g = 12'(g); in_b = 12'(b);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      check({tag, " R1 early"}, int'(out_valid), 0);
      @(negedge clk);
      check({tag, " R1 valid"}, int'(out_valid), 1);
      check({tag, " red"}, int'(out_r), er);
      check({tag, " green"}, int'(out_g), eg);
      check({tag, " blue"}, int'(out_b), eb);
   endtask

   task automatic pixel_model(string tag, int r, int g, int b, bit g9, bit low);
      pixel(tag, r, g, b, model(0, r, g, b, g9, low), model(1, r, g, b, g9, low),
            model(2, r, g, b, g9, low));
   endtask

   task automatic load_table(bit g9);
      int n;
      n = g9 ? 9 : 17;
      @(negedge clk);
      grid_sel = g9; ld_start = 1'b1;
      @(negedge clk);
      ld_start = 1'b0;
      check("R4 start clears error", int'(tbl_err), 0);
      for (int b = 0; b < n; b++)
         for (int g = 0; g < n; g++)
            for (int r = 0; r < n; r++) begin
               ld_wr = 1'b1;
               ld_r = 12'(ent(0, r, g, b)); ld_g = 12'(ent(1, r, g, b)); ld_b = 12'(ent(2, r, g, b));
               if (r == n - 1 && g == n - 1 && b == n - 1)
                  check("R3 not ready before last entry", int'(tbl_ready), 0);
               @(negedge clk);
            end
      ld_wr = 1'b0;
      check("R3 ready after full count", int'(tbl_ready), 1);
   endtask

   task automatic t_reset;
      check("reset out_valid", int'(out_valid), 0);
      check("reset R3 ready", int'(tbl_ready), 0);
      check("reset R4 err", int'(tbl_err), 0);
   endtask

   task automatic t_no_table;
      lut_en = 1'b1;
      pixel("R2 no table", 1234, 56, 4000, 1234, 56, 4000);
      pixel("R2 no table 2", 0, 4095, 777, 0, 4095, 777);
   endtask

   task automatic t_lattice;
      pixel("R5 R6 lattice", 768, 1280, 512, 660, 825, 43);
      pixel("R5 R6 lattice origin", 0, 0, 0, 0, 0, 0);
      pixel_model("R6 lattice model", 16 * 256 - 256, 256, 4 * 256, 0, 0);
   endtask

   task automatic t_interp;
      pixel("R7 hand case", 384, 64, 0, 303, model(1, 384, 64, 0, 0, 0), model(2, 384, 64, 0, 0, 0));
      pixel("R8 half rounds up", 128, 0, 0, 100, 0, 1);
      pixel_model("R7 mix a", 1000, 2000, 3000, 0, 0);
      pixel_model("R7 mix b", 3000, 1500, 700, 0, 0);
      pixel_model("R7 mix c", 100, 3900, 50, 0, 0);
      pixel_model("R7 mix d", 2500, 2270, 2300, 0, 0);
      pixel_model("R7 ties", 2222, 2222, 1111, 0, 0);
   endtask

   task automatic t_top;
      pixel("R11 full scale", 4095, 4095, 4095, 3439,
            model(1, 4095, 4095, 4095, 0, 0), model(2, 4095, 4095, 4095, 0, 0));
      pixel_model("R11 full red", 4095, 0, 2000, 0, 0);
   endtask

   task automatic t_disable;
      lut_en = 1'b0;
      pixel("R2 disabled", 900, 901, 902, 900, 901, 902);
      lut_en = 1'b1;
   endtask

   task automatic t_low;
      prec_sel = 1'b1;
      pixel_model("R9 low lattice", 768, 1280, 512, 0, 1);
      pixel_model("R9 low interp", 3000, 1500, 700, 0, 1);
      pixel_model("R9 low top", 4095, 4095, 4095, 0, 1);
      prec_sel = 1'b0;
   endtask

   task automatic t_overflow;
      @(negedge clk);
      ld_wr = 1'b1;
      @(negedge clk);
      ld_wr = 1'b0;
      check("R4 overflow sets err", int'(tbl_err), 1);
      check("R4 overflow clears ready", int'(tbl_ready), 0);
      pixel("R2 after overflow", 10, 20, 30, 10, 20, 30);
   endtask

   task automatic t_partial;
      @(negedge clk);
      ld_start = 1'b1;
      @(negedge clk);
      ld_start = 1'b0;
      check("R4 clean start", int'(tbl_err), 0);
      ld_wr = 1'b1;
      repeat (10) @(negedge clk);
      ld_wr = 1'b0;
      ld_start = 1'b1;
      @(negedge clk);
      ld_start = 1'b0;
      check("R4 restart mid load", int'(tbl_err), 1);
      check("R3 restart not ready", int'(tbl_ready), 0);
   endtask

   task automatic t_coarse;
      load_table(1'b1);
      pixel("R10 coarse lattice", 1024, 3584, 512, 475, 1120, 12);
      pixel_model("R10 coarse interp", 1300, 2900, 100, 1, 0);
      pixel_model("R11 coarse top", 4095, 4095, 4095, 1, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_table();
      load_table(1'b0);
      t_lattice();
      t_interp();
      t_top();
      t_disable();
      t_low();
      t_overflow();
      t_partial();
      t_coarse();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule